// File: doc/BRIEF.md
# Multi-Slot Instruction Decode Grouper

This block sits between a queue of predecoded instructions and a set of parallel decoders. In every cycle it looks at a small window at the head of the queue and works out how many of those entries leave the queue together and which of them go through a decoder. Each window entry carries its predecode time and a set of flags. Those flags say whether the instruction needs the complex decoder, how many simple decoders stay usable next to it, whether it was fused into the instruction before it, whether it can macro-fuse with the instruction after it, whether it ends the fetch group (a branch or the first half of a fused pair), and whether it carries microcode uops.

The decision is purely combinational from the window and a free-running cycle count held inside the block. The queue owner pops the entries that the pop mask marks. The decoders take the entries that the decode mask marks. When the microcode strobe is high, the microcode sequencer takes the remaining uops of the marked entry. Uop generation and the queue storage belong to other blocks.

Top module: `decode_grouper`

## Requirements
- R1: An internal 8-bit (TS_W) cycle count is 0 in every cycle that reset is held. It is 0 in the first cycle after release and then rises by one per clock, wrapping modulo 2^TS_W. A non-fused entry with timestamp ts may be decoded only when ((now − ts) mod 2^TS_W) lies in [DELAY, 2^(TS_W−1) − 1]. Otherwise it and everything after it are held.
- R2: The popped entries always form a contiguous run starting at window index 0. An invalid entry ends the run, and pop_cnt_o equals the number of popped entries.
- R3: An entry flagged fused-with-previous is popped without being decoded. It uses no decoder slot and needs no eligibility.
- R4: An instruction flagged as needing the complex decoder is decoded only if no other instruction has been decoded earlier in the same cycle. Otherwise the group ends in front of it.
- R5: The slot budget starts at SLOTS (4). A complex instruction sets it to min(budget − 1, its available-simple count), and any other decoded instruction lowers it by one. The group ends when the budget reaches zero.
- R6: A macro-fusible instruction is held when SLOTS − 1 instructions were already decoded this cycle, unless LAST_FUSE_OK is set (default 0).
- R7: A macro-fusible instruction is held when its successor in the window is invalid, not eligible, or outside the window.
- R8: A decoded instruction flagged microcode is popped and decoded, raises ms_o, and ends the group.
- R9: The group ends right after a decoded instruction flagged branch-or-fused-with-next.
- R10: While reset is held, pop_o, dec_o, pop_cnt_o and ms_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ent_valid_i | input | SLOTS+1 | Window entry holds an instruction (index 0 = queue head) |
| ent_ts_i | input | (SLOTS+1)×TS_W | Predecode cycle per entry |
| ent_cplx_i | input | SLOTS+1 | Needs the complex decoder |
| ent_avail_i | input | (SLOTS+1)×CNT_W | Simple decoders usable beside a complex one |
| ent_fprev_i | input | SLOTS+1 | Fused into the previous instruction |
| ent_mfus_i | input | SLOTS+1 | Macro-fusible with the next instruction |
| ent_brfn_i | input | SLOTS+1 | Branch, or fused with the next instruction |
| ent_ms_i | input | SLOTS+1 | Carries microcode uops |
| pop_o | output | SLOTS+1 | Entries leaving the queue this cycle |
| dec_o | output | SLOTS+1 | Entries sent to a decoder this cycle |
| pop_cnt_o | output | $clog2(SLOTS+2) | Number of popped entries |
| ms_o | output | 1 | Microcode hand-off strobe |

## Verification
The bench aims at the interactions between rules. Leading fused entries must not take slots: a design that counted them would stop a four-instruction group early. A complex instruction with a small available count must cut the group short: one that always charged a single slot would over-decode. A macro-fusible instruction in the last slot, or at the window edge, must be held: a design that skipped these tests would let a fused pair split across cycles. Timestamps run past the counter wrap and occasionally lie in the future, so that a plain unsigned comparison would wrongly hold or release entries.

// File: rtl/dgrp_pkg.sv
// Package: shared per-entry flag record for the decode grouper.
// Assumes: flags arrive already decoded from the predecode stage.
package dgrp_pkg;

    typedef struct packed {
        logic cplx;   // needs the complex decoder
        logic fprev;  // fused into the previous instruction
        logic mfus;   // macro-fusible with the next instruction
        logic brfn;   // branch or fused with next: ends the group
        logic ms;     // carries microcode uops
    } ent_flags_t;

    // Pack loose flag bits into one record.
    function automatic ent_flags_t mk_flags(input logic cplx, input logic fprev,
                                            input logic mfus, input logic brfn,
                                            input logic ms);
        ent_flags_t f;
        f.cplx  = cplx;
        f.fprev = fprev;
        f.mfus  = mfus;
        f.brfn  = brfn;
        f.ms    = ms;
        return f;
    endfunction

endpackage

// File: rtl/dgrp_cycle_ctr.sv
// Module: free-running cycle counter used as "now" for eligibility.
// Assumes: timestamps are produced with the same counter, same width.
module dgrp_cycle_ctr #(
    parameter int TS_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [TS_W-1:0] now_o
);

    // Count cycles since reset release, wrapping.
    always_ff @(posedge clk) begin
        if (!rst_n) now_o <= '0;
        else        now_o <= now_o + 1'b1;
    end

    // R1: the counter advances by exactly one per clock out of reset.
    a_r1_tick: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (now_o == $past(now_o) + 1'b1));

endmodule

// File: rtl/dgrp_elig.sv
// Module: per-entry eligibility; true once the predecode-to-decode delay
// has elapsed. Assumes timestamps never lie more than half the counter
// range in the past, so a wrapped difference in the upper half means
// "not yet".
module dgrp_elig #(
    parameter int TS_W  = 8,
    parameter int DELAY = 1
) (
    input  logic [TS_W-1:0] now_i,
    input  logic [TS_W-1:0] ts_i,
    input  logic            valid_i,
    output logic            ok_o
);
    localparam logic [TS_W-1:0] DLY  = TS_W'(DELAY);
    localparam logic [TS_W-1:0] HALF = TS_W'(1) << (TS_W - 1);

    logic [TS_W-1:0] age;

    // Wrapped age of the entry and the window test on it.
    always_comb begin
        age  = now_i - ts_i;
        ok_o = valid_i && (age >= DLY) && (age < HALF);
    end

endmodule

// File: rtl/dgrp_stage.sv
// Module: one link of the grouping chain. Takes the running state
// (still going, decoded count, slot budget) and one window entry, and
// decides whether that entry pops, decodes, hands off to microcode,
// and whether the chain continues past it.
// Assumes: go_i is only high while rem_i is non-zero.
module dgrp_stage
    import dgrp_pkg::*;
#(
    parameter int SLOTS        = 4,
    parameter int CNT_W        = 3,
    parameter bit LAST_FUSE_OK = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_i,
    input  logic [CNT_W-1:0] ndec_i,
    input  logic [CNT_W-1:0] rem_i,
    input  logic             valid_i,
    input  logic             elig_i,
    input  ent_flags_t       flags_i,
    input  logic [CNT_W-1:0] avail_i,
    input  logic             nxt_ok_i,
    output logic             pop_o,
    output logic             dec_o,
    output logic             ms_o,
    output logic             go_o,
    output logic [CNT_W-1:0] ndec_o,
    output logic [CNT_W-1:0] rem_o
);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(SLOTS - 1);

    logic             fuse_hold;
    logic [CNT_W-1:0] rem_dec;
    logic [CNT_W-1:0] rem_nx;

    // Hold rule for a macro-fusible instruction.
    always_comb begin
        fuse_hold = flags_i.mfus &&
                    ((!LAST_FUSE_OK && (ndec_i == LAST_IDX)) || !nxt_ok_i);
    end

    // Slot budget after this instruction.
    always_comb begin
        rem_dec = rem_i - 1'b1;
        if (flags_i.cplx) rem_nx = (avail_i < rem_dec) ? avail_i : rem_dec;
        else              rem_nx = rem_dec;
    end

    // Per-entry grouping decision.
    always_comb begin
        pop_o  = 1'b0;
        dec_o  = 1'b0;
        ms_o   = 1'b0;
        go_o   = 1'b0;
        ndec_o = ndec_i;
        rem_o  = rem_i;
        if (go_i && valid_i) begin
            if (flags_i.fprev) begin
                pop_o = 1'b1;
                go_o  = 1'b1;
            end else if (elig_i && !(flags_i.cplx && (ndec_i != '0)) && !fuse_hold) begin
                pop_o  = 1'b1;
                dec_o  = 1'b1;
                ndec_o = ndec_i + 1'b1;
                if (flags_i.ms) begin
                    ms_o = 1'b1;
                end else begin
                    rem_o = rem_nx;
                    go_o  = (rem_nx != '0) && !flags_i.brfn;
                end
            end
        end
    end

    // R4: a complex instruction only decodes at the head of the group.
    a_r4_cplx_head: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_o && flags_i.cplx) |-> (ndec_i == '0));

    // R1: nothing decodes before its delay has elapsed.
    a_r1_elig_dec: assert property (@(posedge clk) disable iff (!rst_n)
        dec_o |-> elig_i);

    // R7: a decoded macro-fusible instruction always has a ready successor.
    a_r7_fuse_succ: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_o && flags_i.mfus) |-> nxt_ok_i);

endmodule

// File: rtl/decode_grouper.sv
// Module: top of the decode grouper. Inspects SLOTS+1 head-of-queue
// entries (the extra one serves the fusion-successor test) and emits the
// pop mask, decode mask, pop count and microcode strobe for this cycle.
// Assumes: entries outside the valid run carry don't-care fields.
module decode_grouper
    import dgrp_pkg::*;
#(
    parameter int SLOTS        = 4,
    parameter int TS_W         = 8,
    parameter int DELAY        = 1,
    parameter bit LAST_FUSE_OK = 1'b0,
    parameter int CNT_W        = $clog2(SLOTS + 1),
    parameter int PCNT_W       = $clog2(SLOTS + 2)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [SLOTS:0]              ent_valid_i,
    input  logic [SLOTS:0][TS_W-1:0]    ent_ts_i,
    input  logic [SLOTS:0]              ent_cplx_i,
    input  logic [SLOTS:0][CNT_W-1:0]   ent_avail_i,
    input  logic [SLOTS:0]              ent_fprev_i,
    input  logic [SLOTS:0]              ent_mfus_i,
    input  logic [SLOTS:0]              ent_brfn_i,
    input  logic [SLOTS:0]              ent_ms_i,
    output logic [SLOTS:0]              pop_o,
    output logic [SLOTS:0]              dec_o,
    output logic [PCNT_W-1:0]           pop_cnt_o,
    output logic                        ms_o
);
    localparam int W = SLOTS + 1;

    logic [TS_W-1:0]  now;
    logic [W-1:0]     elig;
    logic [W-1:0]     nxt_ok;
    logic [W:0]       go;
    logic [W:0][CNT_W-1:0] ndec;
    logic [W:0][CNT_W-1:0] rem;
    logic [W-1:0]     pop_raw;
    logic [W-1:0]     dec_raw;
    logic [W-1:0]     ms_raw;
    ent_flags_t [W-1:0] flags;

    dgrp_cycle_ctr #(.TS_W(TS_W)) ctr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .now_o (now)
    );

    assign go[0]   = 1'b1;
    assign ndec[0] = '0;
    assign rem[0]  = CNT_W'(SLOTS);

    for (genvar i = 0; i < W; i++) begin : g_ent
        dgrp_elig #(.TS_W(TS_W), .DELAY(DELAY)) elig_i (
            .now_i   (now),
            .ts_i    (ent_ts_i[i]),
            .valid_i (ent_valid_i[i]),
            .ok_o    (elig[i])
        );

        assign flags[i] = mk_flags(ent_cplx_i[i], ent_fprev_i[i], ent_mfus_i[i],
                                   ent_brfn_i[i], ent_ms_i[i]);

        if (i < W - 1) begin : g_nxt
            assign nxt_ok[i] = elig[i+1];
        end else begin : g_edge
            assign nxt_ok[i] = 1'b0;
        end

        dgrp_stage #(.SLOTS(SLOTS), .CNT_W(CNT_W), .LAST_FUSE_OK(LAST_FUSE_OK)) stg_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .go_i     (go[i]),
            .ndec_i   (ndec[i]),
            .rem_i    (rem[i]),
            .valid_i  (ent_valid_i[i]),
            .elig_i   (elig[i]),
            .flags_i  (flags[i]),
            .avail_i  (ent_avail_i[i]),
            .nxt_ok_i (nxt_ok[i]),
            .pop_o    (pop_raw[i]),
            .dec_o    (dec_raw[i]),
            .ms_o     (ms_raw[i]),
            .go_o     (go[i+1]),
            .ndec_o   (ndec[i+1]),
            .rem_o    (rem[i+1])
        );

        // R3: a fused-with-previous entry never reaches a decoder.
        a_r3_fprev_nodec: assert property (@(posedge clk) disable iff (!rst_n)
            dec_o[i] |-> !ent_fprev_i[i]);

        if (i > 0) begin : g_pfx
            // R2: pops form a run from the head.
            a_r2_prefix: assert property (@(posedge clk) disable iff (!rst_n)
                pop_o[i] |-> pop_o[i-1]);
            // R8: nothing pops after a microcode hand-off entry.
            a_r8_ms_tail: assert property (@(posedge clk) disable iff (!rst_n)
                (ms_raw[i-1] && rst_n) |-> !pop_o[i]);
        end
    end

    // Gate outputs during reset and count pops.
    always_comb begin
        pop_o     = rst_n ? pop_raw : '0;
        dec_o     = rst_n ? dec_raw : '0;
        ms_o      = rst_n && (ms_raw != '0);
        pop_cnt_o = '0;
        for (int k = 0; k < W; k++) pop_cnt_o = pop_cnt_o + PCNT_W'(pop_o[k]);
    end

    // R5: never more decodes than slots.
    a_r5_slot_cap: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(dec_o) <= SLOTS);

    // R8: at most one microcode hand-off per cycle.
    a_r8_one_ms: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ms_raw));

    // R2: the count matches the mask.
    a_r2_count: assert property (@(posedge clk) disable iff (!rst_n)
        pop_cnt_o == PCNT_W'($countones(pop_o)));

endmodule

// File: tb/decode_grouper_tb_top.sv
// Bench: drives window contents on the falling edge, compares every
// output against a behavioural model mid-cycle.
module decode_grouper_tb_top;
    localparam int SLOTS = 4;
    localparam int W     = SLOTS + 1;
    localparam int TS_W  = 8;
    localparam int DELAY = 1;
    localparam int CNT_W = 3;
    localparam int PCNT_W = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [W-1:0] v, cx, fp, mf, bf, ms;
    logic [W-1:0][TS_W-1:0]  ts;
    logic [W-1:0][CNT_W-1:0] av;
    logic [W-1:0] pop, dec;
    logic [PCNT_W-1:0] pcnt;
    logic msh;

    int now = 0;
    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    always @(posedge clk) now <= rst_n ? (now + 1) % 256 : 0;

    decode_grouper dut_i (
        .clk(clk), .rst_n(rst_n),
        .ent_valid_i(v), .ent_ts_i(ts), .ent_cplx_i(cx), .ent_avail_i(av),
        .ent_fprev_i(fp), .ent_mfus_i(mf), .ent_brfn_i(bf), .ent_ms_i(ms),
        .pop_o(pop), .dec_o(dec), .pop_cnt_o(pcnt), .ms_o(msh)
    );

    function automatic bit ready(int idx);
        int age;
        age = (now - int'(ts[idx]) + 256) % 256;
        return v[idx] && age >= DELAY && age < 128;
    endfunction

    // Behavioural reference: walk the queue head, returns masks and strobe.
    task automatic model(output logic [W-1:0] ep, output logic [W-1:0] ed,
                         output logic em, output int ecnt);
        int budget = SLOTS;
        int taken = 0;
        ep = '0; ed = '0; em = 1'b0; ecnt = 0;
        for (int i = 0; i < W; i++) begin
            if (!v[i]) break;
            if (fp[i]) begin ep[i] = 1'b1; ecnt++; continue; end
            if (!ready(i)) break;
            if (cx[i] && taken > 0) break;
            if (mf[i] && (taken == SLOTS - 1)) break;
            if (mf[i] && (i == W - 1 || !ready(i + 1))) break;
            ep[i] = 1'b1; ed[i] = 1'b1; ecnt++; taken++;
            if (ms[i]) begin em = 1'b1; break; end
            if (cx[i]) budget = (int'(av[i]) < budget - 1) ? int'(av[i]) : budget - 1;
            else       budget = budget - 1;
            if (budget <= 0 || bf[i]) break;
        end
    endtask

    task automatic compare(input string tag);
        logic [W-1:0] ep, ed;
        logic em;
        int ec;
        if (!rst_n) begin ep = '0; ed = '0; em = 1'b0; ec = 0; end
        else model(ep, ed, em, ec);
        n_chk++;
        if (pop !== ep || dec !== ed || msh !== em || int'(pcnt) != ec) begin
            n_bad++;
            $display("FAIL %s now=%0d pop=%b/%b dec=%b/%b ms=%b/%b cnt=%0d/%0d (actual/expected)",
                     tag, now, pop, ep, dec, ed, msh, em, pcnt, ec);
        end
    endtask

    task automatic clear_win();
        v = '0; cx = '0; fp = '0; mf = '0; bf = '0; ms = '0; av = '0;
        for (int i = 0; i < W; i++) ts[i] = TS_W'(now - 2);
    endtask

    task automatic all_simple();
        clear_win();
        v = '1;
    endtask

    // Apply at the falling edge, check 3 ns later.
    task automatic step(input string tag);
        @(negedge clk);
        #3 compare(tag);
    endtask

    initial begin
        #(200000 * 8);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        clear_win();
        v = '1;
        // R10: outputs held at zero through reset.
        repeat (3) begin @(negedge clk); v = '1; #3 compare("R10"); end
        @(negedge clk); rst_n = 1'b1;

        // R1: entry stamped this very cycle is not ready; one cycle old is.
        @(negedge clk); all_simple(); ts[0] = TS_W'(now); #3 compare("R1");
        @(negedge clk); all_simple(); ts[0] = TS_W'(now - 1); #3 compare("R1");
        // R1: stamp in the future is held.
        @(negedge clk); all_simple(); ts[0] = TS_W'(now + 5); #3 compare("R1");
        // R2: invalid entry stops the run.
        @(negedge clk); all_simple(); v[2] = 1'b0; #3 compare("R2");
        // R3: leading fused entry takes no slot, five pops.
        @(negedge clk); all_simple(); fp[0] = 1'b1; ts[0] = TS_W'(now); #3 compare("R3");
        // R4: complex behind a simple one ends the group.
        @(negedge clk); all_simple(); cx[1] = 1'b1; av[1] = 3'd3; #3 compare("R4");
        // R5: complex at head with small budget.
        @(negedge clk); all_simple(); cx[0] = 1'b1; av[0] = 3'd1; #3 compare("R5");
        @(negedge clk); all_simple(); cx[0] = 1'b1; av[0] = 3'd0; #3 compare("R5");
        @(negedge clk); all_simple(); cx[0] = 1'b1; av[0] = 3'd4; #3 compare("R5");
        // R6: macro-fusible in the last slot is held.
        @(negedge clk); all_simple(); mf[3] = 1'b1; fp[4] = 1'b1; #3 compare("R6");
        // R7: successor not ready, or beyond the window.
        @(negedge clk); all_simple(); mf[0] = 1'b1; ts[1] = TS_W'(now); #3 compare("R7");
        @(negedge clk); all_simple(); fp[0] = 1'b1; fp[1] = 1'b1; fp[2] = 1'b1;
                        fp[3] = 1'b1; mf[4] = 1'b1; #3 compare("R7");
        @(negedge clk); all_simple(); mf[0] = 1'b1; bf[0] = 1'b1; fp[1] = 1'b1; #3 compare("R7");
        // R8: microcode entry pops, strobes and ends the group.
        @(negedge clk); all_simple(); ms[1] = 1'b1; #3 compare("R8");
        // R9: branch ends the group right after itself.
        @(negedge clk); all_simple(); bf[0] = 1'b1; #3 compare("R9");
        @(negedge clk); all_simple(); bf[2] = 1'b1; #3 compare("R9");

        // Mixed traffic, including counter wrap (R2 main function).
        for (int n = 0; n < 3000; n++) begin
            @(negedge clk);
            for (int i = 0; i < W; i++) begin
                v[i]  = ($urandom % 10) != 0;
                ts[i] = (($urandom % 16) == 0) ? TS_W'(now + 3) : TS_W'(now - ($urandom % 4));
                fp[i] = ($urandom % 6) == 0;
                cx[i] = ($urandom % 5) == 0;
                mf[i] = ($urandom % 5) == 0;
                bf[i] = ($urandom % 6) == 0;
                ms[i] = ($urandom % 10) == 0;
                av[i] = CNT_W'($urandom % 5);
            end
            #3 compare("R2");
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule